// File: doc/BRIEF.md
# Receive Error Flags and Interrupt Request Control

This block keeps the sticky error state of a serial receiver together with its receiver-enable flag, and turns event pulses from the transmit and receive engines into three interrupt request lines. The receive engine reports parity, framing and overrun problems as one-cycle strobes. Each kind of error is recorded only while its own check is switched on in the control register. Once recorded, an error stays visible in a readable state word until software removes it.

Software reaches the block through a single write port with a two-bit register select. The select chooses one of four registers: a control register, a write-only flag command register, an interrupt enable register and an interrupt acknowledge register. Flags are never written directly. A command write sets or clears individual flags, one bit per action. When a hardware set and a software clear hit the same flag in the same cycle, the set is kept, so no event is lost. The TX and RX requests are latched events. The error request is a level formed from the error flags. A TX-buffer level input shares the TX line under its own enable.

Top module: `rx_err_irq_ctrl`

## Requirements
- R1: After reset, state_word, ctrl_word, rx_enable, irq_tx, irq_rx and irq_err are all 0.
- R2: state_word shows the parity error flag at bit 16, the framing error flag at bit 17 and the overrun flag at bit 19. All other bits read 0.
- R3: A parity, framing or overrun strobe sets its flag only while its check enable is 1. The enables are control bits 20 (parity), 17 (framing) and 19 (overrun). A strobe whose check is disabled leaves its flag unchanged. An overrun strobe touches only the overrun flag.
- R4: Error flags are sticky. A write to the flag command register (select 1) clears the parity flag with bit 2, the framing flag with bit 3 and the overrun flag with bit 5. Each of these bits clears only its own flag.
- R5: In the flag command register, bit 0 clears rx_enable and bit 1 sets it. If both bits are 1, rx_enable becomes 1.
- R6: If an accepted error strobe and a clear command for the same flag arrive in the same cycle, the flag ends up set.
- R7: The control register (select 0) keeps only these fields: the mode field in bits 2:0, odd parity in bit 5, two stop bits in bit 7, and the check enables in bits 17, 19 and 20. All other bits read back 0. In the mode field, 2 means 7-bit characters and 0 means 8-bit characters; any other code is stored as 0. The outputs parity_odd, two_stop and char7 follow these fields.
- R8: The interrupt enable register is select 2, with bit 0 for TX, bit 1 for RX, bit 2 for error and bit 3 for TX-buffer. A tx_evt or rx_evt pulse latches a pending request, even while that source is disabled. The pending request drives irq_tx or irq_rx while the matching enable is 1. Writing 1 to bit 0 or bit 1 of the acknowledge register (select 3) clears the TX or RX pending request. An event arriving in the same cycle as its acknowledge wins.
- R9: irq_err is 1 exactly when at least one error flag is set and error enable bit 2 is 1. Writing 1 to acknowledge bit 2 clears all three error flags.
- R10: irq_tx is also driven by the txbuf_req level input while enable bit 3 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 flag command, 2 interrupt enable, 3 interrupt acknowledge |
| wr_data | input | 32 | Write data |
| par_err_stb | input | 1 | Parity error strobe from the receive engine |
| frm_err_stb | input | 1 | Framing error strobe from the receive engine |
| ovr_err_stb | input | 1 | Overrun strobe from the receive engine |
| tx_evt | input | 1 | Transmit event pulse |
| rx_evt | input | 1 | Receive event pulse |
| txbuf_req | input | 1 | Transmit buffer level request |
| state_word | output | 32 | Error flag state word |
| ctrl_word | output | 32 | Control register readback |
| rx_enable | output | 1 | Receiver enable |
| parity_odd | output | 1 | Odd parity selected |
| two_stop | output | 1 | Two stop bits selected |
| char7 | output | 1 | 7-bit character mode selected |
| irq_tx | output | 1 | TX interrupt request |
| irq_rx | output | 1 | RX interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
Every register write, strobe and event is captured at one clock edge. Its effect shows on the flags, the pending requests and the stored control word right after that same edge. The three request lines and the state word are combinational from that registered state, so they are also due one edge after the stimulus. The txbuf_req path is the exception: it is a pure level path and has no register at all. The bench drives each stimulus on a falling edge and drops it on the next falling edge. It then compares the outputs at that second falling edge, which is exactly one rising edge after the stimulus.

// File: rtl/rx_err_irq_pkg.sv
package rx_err_irq_pkg;
  localparam int WORD_W = 32;
  localparam int NERR   = 3;
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_OVR = 2;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_FLGCMD = 2'd1,
    SEL_IRQEN  = 2'd2,
    SEL_IRQACK = 2'd3
  } wsel_e;

  localparam int MODE_W   = 3;
  localparam logic [MODE_W-1:0] MODE_8 = 3'd0;
  localparam logic [MODE_W-1:0] MODE_7 = 3'd2;
  localparam int CB_ODD  = 5;
  localparam int CB_STP2 = 7;

  localparam int CMD_RXOFF = 0;
  localparam int CMD_RXON  = 1;

  localparam int IRQ_TX    = 0;
  localparam int IRQ_RX    = 1;
  localparam int IRQ_ERR   = 2;
  localparam int IRQ_TXBUF = 3;
  localparam int IRQ_N     = 4;

  function automatic int state_pos(input int e);
    case (e)
      ERR_PAR: return 16;
      ERR_FRM: return 17;
      default: return 19;
    endcase
  endfunction

  function automatic int chk_pos(input int e);
    case (e)
      ERR_PAR: return 20;
      ERR_FRM: return 17;
      default: return 19;
    endcase
  endfunction

  function automatic int clr_pos(input int e);
    case (e)
      ERR_PAR: return 2;
      ERR_FRM: return 3;
      default: return 5;
    endcase
  endfunction

  // sticky update: a set in the same cycle as a clear is kept
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  function automatic logic [MODE_W-1:0] legal_mode(input logic [MODE_W-1:0] m);
    return (m == MODE_7) ? MODE_7 : MODE_8;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_filter(input logic [WORD_W-1:0] d);
    logic [WORD_W-1:0] r;
    r = '0;
    r[MODE_W-1:0] = legal_mode(d[MODE_W-1:0]);
    r[CB_ODD]  = d[CB_ODD];
    r[CB_STP2] = d[CB_STP2];
    for (int e = 0; e < NERR; e++) r[chk_pos(e)] = d[chk_pos(e)];
    return r;
  endfunction
endpackage

// File: rtl/sticky_bit.sv
module sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import rx_err_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= sticky_next(q_o, set_i, clr_i);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i) |=> q_o); // R4
  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R4
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
  import rx_err_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] ctrl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_o <= '0;
    else if (wr_i) ctrl_o <= ctrl_filter(data_i);
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_o[MODE_W-1:0] == MODE_8) || (ctrl_o[MODE_W-1:0] == MODE_7)); // R7
  AST_CTRL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_o)); // R7
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import rx_err_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_wr_i,
  input  logic             ack_wr_i,
  input  logic [IRQ_N-1:0] data_i,
  input  logic             tx_evt_i,
  input  logic             rx_evt_i,
  input  logic             txbuf_req_i,
  input  logic             err_any_i,
  output logic [IRQ_N-1:0] ien_o,
  output logic             irq_tx_o,
  output logic             irq_rx_o,
  output logic             irq_err_o
);
  logic [1:0] evt_w;
  logic [1:0] ack_w;
  logic [1:0] pend_w;

  assign evt_w = {rx_evt_i, tx_evt_i};
  assign ack_w = {ack_wr_i & data_i[IRQ_RX], ack_wr_i & data_i[IRQ_TX]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ien_o <= '0;
    else if (ien_wr_i) ien_o <= data_i;
  end

  for (genvar s = 0; s < 2; s++) begin : g_pend
    sticky_bit u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (evt_w[s]),
      .clr_i (ack_w[s]),
      .q_o   (pend_w[s])
    );
  end

  assign irq_tx_o  = (pend_w[IRQ_TX] & ien_o[IRQ_TX]) | (txbuf_req_i & ien_o[IRQ_TXBUF]);
  assign irq_rx_o  = pend_w[IRQ_RX] & ien_o[IRQ_RX];
  assign irq_err_o = err_any_i & ien_o[IRQ_ERR];

  AST_RX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt_i && ien_o[IRQ_RX] && !ien_wr_i) |=> irq_rx_o); // R8
  AST_TX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w[0] && !tx_evt_i && !txbuf_req_i) |=> !irq_tx_o); // R8
endmodule

// File: rtl/rx_err_irq_ctrl.sv
module rx_err_irq_ctrl
  import rx_err_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              par_err_stb,
  input  logic              frm_err_stb,
  input  logic              ovr_err_stb,
  input  logic              tx_evt,
  input  logic              rx_evt,
  input  logic              txbuf_req,
  output logic [WORD_W-1:0] state_word,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              rx_enable,
  output logic              parity_odd,
  output logic              two_stop,
  output logic              char7,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err
);
  logic ctrl_wr, cmd_wr, ien_wr, ack_wr;
  logic [NERR-1:0] err_stb, err_set, err_clr, err_q;
  logic [IRQ_N-1:0] ien_w;
  logic rx_on, rx_off;

  assign ctrl_wr = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);
  assign cmd_wr  = wr_en && (wsel_e'(wr_sel) == SEL_FLGCMD);
  assign ien_wr  = wr_en && (wsel_e'(wr_sel) == SEL_IRQEN);
  assign ack_wr  = wr_en && (wsel_e'(wr_sel) == SEL_IRQACK);

  ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (ctrl_wr),
    .data_i (wr_data),
    .ctrl_o (ctrl_word)
  );

  assign parity_odd = ctrl_word[CB_ODD];
  assign two_stop   = ctrl_word[CB_STP2];
  assign char7      = (ctrl_word[MODE_W-1:0] == MODE_7);

  assign err_stb[ERR_PAR] = par_err_stb;
  assign err_stb[ERR_FRM] = frm_err_stb;
  assign err_stb[ERR_OVR] = ovr_err_stb;

  for (genvar e = 0; e < NERR; e++) begin : g_err
    assign err_set[e] = err_stb[e] & ctrl_word[chk_pos(e)];
    assign err_clr[e] = (cmd_wr & wr_data[clr_pos(e)]) | (ack_wr & wr_data[IRQ_ERR]);
    sticky_bit u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (err_set[e]),
      .clr_i (err_clr[e]),
      .q_o   (err_q[e])
    );
    AST_CHK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_stb[e] && !ctrl_word[chk_pos(e)] && !err_q[e]) |=> !err_q[e]); // R3
  end

  always_comb begin
    state_word = '0;
    for (int e = 0; e < NERR; e++) state_word[state_pos(e)] = err_q[e];
  end

  assign rx_on  = cmd_wr & wr_data[CMD_RXON];
  assign rx_off = cmd_wr & wr_data[CMD_RXOFF];

  sticky_bit u_rxen (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (rx_on),
    .clr_i (rx_off),
    .q_o   (rx_enable)
  );

  irq_unit u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ien_wr_i    (ien_wr),
    .ack_wr_i    (ack_wr),
    .data_i      (wr_data[IRQ_N-1:0]),
    .tx_evt_i    (tx_evt),
    .rx_evt_i    (rx_evt),
    .txbuf_req_i (txbuf_req),
    .err_any_i   (|err_q),
    .ien_o       (ien_w),
    .irq_tx_o    (irq_tx),
    .irq_rx_o    (irq_rx),
    .irq_err_o   (irq_err)
  );

  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|err_set) && ien_w[IRQ_ERR] && !ien_wr) |=> irq_err); // R9
  AST_RXEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    rx_on |=> rx_enable); // R5
  AST_ACK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && wr_data[IRQ_ERR] && !(|err_stb)) |=> (state_word == '0)); // R9
endmodule

// File: tb/rx_err_irq_ctrl_bench.sv
module rx_err_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic par_err_stb = 1'b0, frm_err_stb = 1'b0, ovr_err_stb = 1'b0;
  logic tx_evt = 1'b0, rx_evt = 1'b0, txbuf_req = 1'b0;
  logic [31:0] state_word, ctrl_word;
  logic rx_enable, parity_odd, two_stop, char7, irq_tx, irq_rx, irq_err;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rx_err_irq_ctrl u_rx_err_irq_ctrl (.*);

  // {expected flags, strobes, check enables}; each triple is {par, frm, ovr}
  localparam logic [8:0] VEC [8] = '{
    {3'b111, 3'b111, 3'b111},
    {3'b000, 3'b111, 3'b000},
    {3'b101, 3'b111, 3'b101},
    {3'b010, 3'b011, 3'b010},
    {3'b100, 3'b100, 3'b111},
    {3'b001, 3'b001, 3'b111},
    {3'b100, 3'b101, 3'b110},
    {3'b010, 3'b110, 3'b011}
  };

  function automatic logic [31:0] sw_of(input logic [2:0] f);
    return {12'd0, f[0], 1'b0, f[1], f[2], 16'd0};
  endfunction

  function automatic logic [31:0] en_of(input logic [2:0] f);
    return {11'd0, f[2], f[0], 1'b0, f[1], 17'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] sel, input logic [31:0] d,
                      input logic [2:0] stb, input logic tx, input logic rx);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d;
    {par_err_stb, frm_err_stb, ovr_err_stb} = stb;
    tx_evt = tx; rx_evt = rx;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    {par_err_stb, frm_err_stb, ovr_err_stb} = 3'b000;
    tx_evt = 1'b0; rx_evt = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    step(1'b1, sel, d, 3'b000, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 state", state_word, 32'h0);
    check("R1 ctrl", ctrl_word, 32'h0);
    check("R1 lines", {29'd0, rx_enable, irq_tx, irq_rx}, 32'h0);
    check("R1 err", {31'd0, irq_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", state_word, 32'h0);

    // R2 R3 table walk
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, en_of(VEC[i][2:0]));
      wr(2'd3, 32'h4);
      step(1'b0, 2'd0, 32'h0, VEC[i][5:3], 1'b0, 1'b0);
      check($sformatf("R2 R3 vector %0d", i), state_word, sw_of(VEC[i][8:6]));
    end

    // R4 selective clear and stickiness
    wr(2'd0, 32'h001A0000);
    step(1'b0, 2'd0, 32'h0, 3'b111, 1'b0, 1'b0);
    check("R4 all set", state_word, 32'h000B0000);
    wr(2'd1, 32'h4);
    check("R4 clear parity", state_word, 32'h000A0000);
    wr(2'd1, 32'h20);
    check("R4 clear overrun", state_word, 32'h00020000);
    repeat (3) @(negedge clk);
    check("R4 sticky", state_word, 32'h00020000);
    wr(2'd1, 32'h8);
    check("R4 clear framing", state_word, 32'h0);

    // R5 receiver enable
    wr(2'd1, 32'h2);
    check("R5 set", {31'd0, rx_enable}, 32'h1);
    wr(2'd1, 32'h1);
    check("R5 clear", {31'd0, rx_enable}, 32'h0);
    wr(2'd1, 32'h3);
    check("R5 both", {31'd0, rx_enable}, 32'h1);
    wr(2'd1, 32'h1);
    check("R5 clear again", {31'd0, rx_enable}, 32'h0);

    // R6 set beats clear
    step(1'b1, 2'd1, 32'h4, 3'b100, 1'b0, 1'b0);
    check("R6 set wins", state_word, 32'h00010000);
    wr(2'd1, 32'h4);
    check("R6 cleared after", state_word, 32'h0);

    // R7 control fields
    wr(2'd0, 32'hFFFFFFFF);
    check("R7 filtered", ctrl_word, 32'h001A00A0);
    check("R7 fields", {29'd0, parity_odd, two_stop, char7}, 32'h6);
    wr(2'd0, 32'h2);
    check("R7 mode7", {29'd0, parity_odd, two_stop, char7}, 32'h1);
    check("R7 mode7 word", ctrl_word, 32'h2);
    wr(2'd0, 32'h3);
    check("R7 illegal mode", ctrl_word, 32'h0);
    wr(2'd0, 32'h001A0000);

    // R8 tx / rx requests
    step(1'b0, 2'd0, 32'h0, 3'b000, 1'b1, 1'b0);
    check("R8 tx masked", {31'd0, irq_tx}, 32'h0);
    wr(2'd2, 32'h1);
    check("R8 tx pending shows", {31'd0, irq_tx}, 32'h1);
    wr(2'd3, 32'h1);
    check("R8 tx ack", {31'd0, irq_tx}, 32'h0);
    wr(2'd2, 32'h3);
    step(1'b0, 2'd0, 32'h0, 3'b000, 1'b0, 1'b1);
    check("R8 rx raise", {30'd0, irq_tx, irq_rx}, 32'h1);
    step(1'b1, 2'd3, 32'h2, 3'b000, 1'b0, 1'b1);
    check("R8 event beats ack", {31'd0, irq_rx}, 32'h1);
    wr(2'd3, 32'h2);
    check("R8 rx ack", {31'd0, irq_rx}, 32'h0);

    // R9 error line
    wr(2'd2, 32'h7);
    step(1'b0, 2'd0, 32'h0, 3'b010, 1'b0, 1'b0);
    check("R9 err raise", {31'd0, irq_err}, 32'h1);
    wr(2'd2, 32'h3);
    check("R9 err masked", {31'd0, irq_err}, 32'h0);
    check("R9 flag kept", state_word, 32'h00020000);
    wr(2'd2, 32'h7);
    check("R9 err unmask", {31'd0, irq_err}, 32'h1);
    wr(2'd3, 32'h4);
    check("R9 ack clears flags", state_word, 32'h0);
    check("R9 err low", {31'd0, irq_err}, 32'h0);

    // R10 tx buffer level
    wr(2'd2, 32'h8);
    @(negedge clk); txbuf_req = 1'b1;
    @(negedge clk);
    check("R10 level high", {31'd0, irq_tx}, 32'h1);
    txbuf_req = 1'b0;
    @(negedge clk);
    check("R10 level low", {31'd0, irq_tx}, 32'h0);
    wr(2'd2, 32'h0);
    txbuf_req = 1'b1;
    @(negedge clk);
    check("R10 disabled", {31'd0, irq_tx}, 32'h0);
    txbuf_req = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule